// File: doc/BRIEF.md
# MAC address table command engine

This block keeps a sixteen-entry table of station addresses and changes it under the control of a host processor. Each slot holds a 48-bit MAC address, a 3-bit port number and five flags: valid, locked, filtered, new and aged. The host presents an opcode, an address and, where the command needs one, a port number for one clock cycle. It then polls a two-field result (a status and a 4-bit error code) until the command has finished.

Commands either act on the slot that holds a given address (insert, lock, mark as filtered, remove, change port), or walk the table. A walk pairs a "first" opcode with a "next" opcode and returns the index and contents of each slot in a chosen class: every slot, valid slots, slots with one particular flag set, or slots whose port number equals the one given with the command. The engine looks at one slot per clock cycle. Each finished command sets a sticky interrupt source bit, and a mask decides whether that bit drives the interrupt line.

Top module: `mac_cmd_engine`

## Requirements
- R1: While reset is asserted and after it is released, `res_stat` is 2'b00, `res_err` is 0, `int_src` is 0, `irq` is 0 and the readout (`rd_idx`, `rd_mac`, `rd_pid`, flags) is all zero.
- R2: A `cmd_valid` pulse while `res_stat` is not 2'b01 is accepted, and `res_stat` reads 2'b01 (busy) from the next cycle until the command ends. A `cmd_valid` pulse while busy is ignored and changes neither the table nor the command in progress.
- R3: A finished command leaves `res_stat` at 2'b10 and `res_err` at 0000 for success, 0001 when no slot matched, 0010 when an insert finds the table full, or 0011 for an opcode that is not defined (for example 0x12 or 0x77). `res_err` is non-zero only when `res_stat` is 2'b10.
- R4: Opcode 0x09 inserts the address into the lowest-indexed slot that is not valid, with valid and new set, locked, filtered and aged clear, and the given port. If a valid slot already holds the address, only its port is changed and no second copy is made. This also works when the table is full. Inserting a new address into a full table ends with 0010.
- R5: Opcodes 0x0A (set locked), 0x0B (set filtered) and 0x0D (replace the port) act on the valid slot holding the address. If no such slot exists they end with 0001.
- R6: Opcode 0x0C clears every field of the slot holding the address (address, port and flags all zero). A missing address ends with 0001.
- R7: Opcodes 0x10 and 0x11 walk every slot, valid or not, and each step returns the slot's index, address, port and flags on the readout outputs.
- R8: Flag walks return only slots with the named property: 0x20/0x21 valid, 0x30/0x31 new, 0x40/0x41 aged, 0x50/0x51 locked, 0x60/0x61 filtered. The readout flag order is {valid, locked, filtered, new, aged}.
- R9: Opcodes 0x80 and 0x81 return valid slots whose port equals `cmd_pid`.
- R10: A first opcode (even low byte) starts its scan at index 0. A next opcode (odd low byte) starts one past the index most recently returned by any walk. When no slot is left, the command ends with 0001, and later next opcodes keep ending with 0001. A command that does not return a slot leaves the readout unchanged.
- R11: Opcode 0xFF empties the table, returns the walk position to index 0, clears the readout and all interrupt sources, and ends with 2'b10 / 0000. Its own completion bit stays set.
- R12: `int_src[5]` becomes 1 at the edge where a command ends. Writing 1 to a bit of `int_clr` clears that source bit. `irq` is high exactly when some bit of `int_src & int_mask` is 1.
- R13: One slot is examined per cycle. A command that succeeds on the slot at index k reads busy for k+1 cycles after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_mac | input | 48 | Address operand |
| cmd_pid | input | 3 | Port operand |
| int_mask | input | 8 | Interrupt enable per source bit |
| int_clr | input | 8 | Write-one-to-clear strobe per source bit |
| res_stat | output | 2 | 00 idle, 01 busy, 10 done |
| res_err | output | 4 | Error code of the last finished command |
| rd_idx | output | 4 | Index of the slot last returned by a walk |
| rd_mac | output | 48 | Address of that slot |
| rd_pid | output | 3 | Port of that slot |
| rd_vld | output | 1 | Valid flag of that slot |
| rd_lck | output | 1 | Locked flag of that slot |
| rd_flt | output | 1 | Filtered flag of that slot |
| rd_new | output | 1 | New flag of that slot |
| rd_aged | output | 1 | Aged flag of that slot |
| int_src | output | 8 | Sticky interrupt sources; bit 5 is command done |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is a settled two-state value at each rising edge. They also assume `cmd_valid` is a pulse the host raises only to start a command, so a done status stays put until the next strobe. The readout property depends on the readout changing only when a command finishes. The bench changes inputs on falling edges only, holds each strobe and each clear for exactly one cycle, and changes the mask only while no command is running. The single strobe sent during a busy scan is the one intended case of input arriving outside the idle window.

// File: rtl/mactbl_pkg.sv
package mactbl_pkg;

  parameter int MAC_W = 48;
  parameter int PID_W = 3;

  typedef struct packed {
    logic [MAC_W-1:0] mac;
    logic [PID_W-1:0] pid;
    logic             vld;
    logic             lck;
    logic             flt;
    logic             nw;
    logic             agd;
  } tbl_ent_t;

  typedef enum logic [2:0] {
    A_BAD, A_ADD, A_LOCK, A_FILT, A_DEL, A_PID, A_RST, A_WALK
  } act_e;

  typedef enum logic [2:0] {
    K_NONE, K_ALL, K_VALID, K_NEW, K_AGED, K_LOCK, K_FILT, K_PID
  } kind_e;

  typedef struct packed {
    act_e  act;
    kind_e kind;
    logic  nxt;
  } dec_t;

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_BUSY = 2'b01;
  localparam logic [1:0] ST_DONE = 2'b10;

  localparam logic [3:0] ERR_NONE  = 4'h0;
  localparam logic [3:0] ERR_MISS  = 4'h1;
  localparam logic [3:0] ERR_FULL  = 4'h2;
  localparam logic [3:0] ERR_BADOP = 4'h3;

  function automatic dec_t decode_op(input logic [7:0] op);
    dec_t d;
    d.act  = A_BAD;
    d.kind = K_NONE;
    d.nxt  = op[0];
    case (op)
      8'h09: d.act = A_ADD;
      8'h0A: d.act = A_LOCK;
      8'h0B: d.act = A_FILT;
      8'h0C: d.act = A_DEL;
      8'h0D: d.act = A_PID;
      8'hFF: d.act = A_RST;
      8'h10, 8'h11: begin d.act = A_WALK; d.kind = K_ALL;   end
      8'h20, 8'h21: begin d.act = A_WALK; d.kind = K_VALID; end
      8'h30, 8'h31: begin d.act = A_WALK; d.kind = K_NEW;   end
      8'h40, 8'h41: begin d.act = A_WALK; d.kind = K_AGED;  end
      8'h50, 8'h51: begin d.act = A_WALK; d.kind = K_LOCK;  end
      8'h60, 8'h61: begin d.act = A_WALK; d.kind = K_FILT;  end
      8'h80, 8'h81: begin d.act = A_WALK; d.kind = K_PID;   end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mactbl_rst_sync.sv
module mactbl_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/mactbl_store.sv
module mactbl_store
  import mactbl_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   widx,
  input  tbl_ent_t                   wdata,
  output tbl_ent_t [DEPTH-1:0]       ents
);
  localparam int IW = $clog2(DEPTH);

  tbl_ent_t [DEPTH-1:0] ent_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic ld;
    assign ld = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[g] <= '0;
      else if (clr) ent_q[g] <= '0;
      else if (ld)  ent_q[g] <= wdata;
    end
  end

  assign ents = ent_q;
endmodule

// File: rtl/mactbl_match.sv
module mactbl_match
  import mactbl_pkg::*;
(
  input  tbl_ent_t          ent,
  input  kind_e             kind,
  input  logic [MAC_W-1:0]  key_mac,
  input  logic [PID_W-1:0]  key_pid,
  output logic              mac_hit,
  output logic              walk_hit
);
  always_comb begin
    mac_hit = ent.vld && (ent.mac == key_mac);
    case (kind)
      K_ALL:   walk_hit = 1'b1;
      K_VALID: walk_hit = ent.vld;
      K_NEW:   walk_hit = ent.vld && ent.nw;
      K_AGED:  walk_hit = ent.vld && ent.agd;
      K_LOCK:  walk_hit = ent.vld && ent.lck;
      K_FILT:  walk_hit = ent.vld && ent.flt;
      K_PID:   walk_hit = ent.vld && (ent.pid == key_pid);
      default: walk_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/mactbl_irq.sv
module mactbl_irq #(
  parameter int IRQ_W    = 8,
  parameter int DONE_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_done,
  input  logic             clr_all,
  input  logic [IRQ_W-1:0] clr_w1c,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] src,
  output logic             irq
);
  logic [IRQ_W-1:0] src_q, src_d;

  always_comb begin
    src_d = clr_all ? '0 : (src_q & ~clr_w1c);
    if (set_done) src_d[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign src = src_q;
  assign irq = |(src_q & mask);
endmodule

// File: rtl/mac_cmd_engine.sv
module mac_cmd_engine
  import mactbl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IRQ_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [7:0]               cmd_op,
  input  logic [MAC_W-1:0]         cmd_mac,
  input  logic [PID_W-1:0]         cmd_pid,
  input  logic [IRQ_W-1:0]         int_mask,
  input  logic [IRQ_W-1:0]         int_clr,
  output logic [1:0]               res_stat,
  output logic [3:0]               res_err,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [MAC_W-1:0]         rd_mac,
  output logic [PID_W-1:0]         rd_pid,
  output logic                     rd_vld,
  output logic                     rd_lck,
  output logic                     rd_flt,
  output logic                     rd_new,
  output logic                     rd_aged,
  output logic [IRQ_W-1:0]         int_src,
  output logic                     irq
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DEPTH - 1);
  localparam logic [CW-1:0] END_IDX  = CW'(DEPTH);
  localparam int DONE_BIT = 5;

  typedef enum logic {S_IDLE, S_SCAN} fsm_e;

  logic rst_n_s;
  mactbl_rst_sync u_rst (.clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s));

  // state
  fsm_e              st_q, st_d;
  act_e              act_q, act_d;
  kind_e             kind_q, kind_d;
  logic [MAC_W-1:0]  mac_q;
  logic [PID_W-1:0]  pid_q;
  logic [CW-1:0]     idx_q, idx_d, ptr_q, ptr_d;
  logic              fr_vld_q, fr_vld_d;
  logic [IW-1:0]     fr_idx_q, fr_idx_d;
  tbl_ent_t          rd_q, rd_d;
  logic [IW-1:0]     rdi_q, rdi_d;
  logic [1:0]        rs_q, rs_d;
  logic [3:0]        re_q, re_d;
  logic              acc;

  // table interface
  tbl_ent_t [DEPTH-1:0] ents;
  tbl_ent_t          cur, wdata;
  logic              we, clr_tbl;
  logic [IW-1:0]     widx, idx_lo;
  logic              in_rng, mac_hit, walk_hit;

  // completion
  logic              fin, done_p, src_clr_all;
  logic [3:0]        fin_err;
  dec_t              dec_in;

  mactbl_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n_s), .clr(clr_tbl), .we(we),
    .widx(widx), .wdata(wdata), .ents(ents)
  );

  assign idx_lo = idx_q[IW-1:0];
  assign in_rng = (idx_q < END_IDX);
  assign cur    = in_rng ? ents[idx_lo] : '0;

  mactbl_match u_match (
    .ent(cur), .kind(kind_q), .key_mac(mac_q), .key_pid(pid_q),
    .mac_hit(mac_hit), .walk_hit(walk_hit)
  );

  mactbl_irq #(.IRQ_W(IRQ_W), .DONE_BIT(DONE_BIT)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .set_done(done_p), .clr_all(src_clr_all),
    .clr_w1c(int_clr), .mask(int_mask), .src(int_src), .irq(irq)
  );

  assign dec_in = decode_op(cmd_op);
  assign acc    = (st_q == S_IDLE) && cmd_valid;

  // next-state logic
  always_comb begin
    st_d        = st_q;
    act_d       = act_q;
    kind_d      = kind_q;
    idx_d       = idx_q;
    ptr_d       = ptr_q;
    fr_vld_d    = fr_vld_q;
    fr_idx_d    = fr_idx_q;
    rd_d        = rd_q;
    rdi_d       = rdi_q;
    rs_d        = rs_q;
    re_d        = re_q;
    we          = 1'b0;
    widx        = idx_lo;
    wdata       = cur;
    clr_tbl     = 1'b0;
    src_clr_all = 1'b0;
    fin         = 1'b0;
    fin_err     = ERR_NONE;

    case (st_q)
      S_IDLE: begin
        if (cmd_valid) begin
          act_d    = dec_in.act;
          kind_d   = dec_in.kind;
          idx_d    = (dec_in.act == A_WALK && dec_in.nxt) ? ptr_q : '0;
          fr_vld_d = 1'b0;
          rs_d     = ST_BUSY;
          re_d     = ERR_NONE;
          st_d     = S_SCAN;
        end
      end
      S_SCAN: begin
        case (act_q)
          A_RST: begin
            clr_tbl     = 1'b1;
            src_clr_all = 1'b1;
            ptr_d       = '0;
            rd_d        = '0;
            rdi_d       = '0;
            fin         = 1'b1;
          end
          A_BAD: begin
            fin     = 1'b1;
            fin_err = ERR_BADOP;
          end
          A_WALK: begin
            if (!in_rng) begin
              ptr_d   = END_IDX;
              fin     = 1'b1;
              fin_err = ERR_MISS;
            end else if (walk_hit) begin
              rd_d  = cur;
              rdi_d = idx_lo;
              ptr_d = idx_q + 1'b1;
              fin   = 1'b1;
            end else if (idx_q == LAST_IDX) begin
              ptr_d   = END_IDX;
              fin     = 1'b1;
              fin_err = ERR_MISS;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
          default: begin
            if (mac_hit) begin
              we  = 1'b1;
              fin = 1'b1;
              case (act_q)
                A_ADD:   wdata.pid = pid_q;
                A_PID:   wdata.pid = pid_q;
                A_LOCK:  wdata.lck = 1'b1;
                A_FILT:  wdata.flt = 1'b1;
                default: wdata     = '0;
              endcase
            end else begin
              if (!cur.vld && !fr_vld_q) begin
                fr_vld_d = 1'b1;
                fr_idx_d = idx_lo;
              end
              if (idx_q == LAST_IDX) begin
                fin = 1'b1;
                if (act_q == A_ADD) begin
                  if (fr_vld_d) begin
                    we        = 1'b1;
                    widx      = fr_idx_d;
                    wdata     = '0;
                    wdata.mac = mac_q;
                    wdata.pid = pid_q;
                    wdata.vld = 1'b1;
                    wdata.nw  = 1'b1;
                  end else begin
                    fin_err = ERR_FULL;
                  end
                end else begin
                  fin_err = ERR_MISS;
                end
              end else begin
                idx_d = idx_q + 1'b1;
              end
            end
          end
        endcase
      end
      default: st_d = S_IDLE;
    endcase

    if (fin) begin
      st_d = S_IDLE;
      rs_d = ST_DONE;
      re_d = fin_err;
    end
    done_p = fin;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mac_q <= '0;
      pid_q <= '0;
    end else if (acc) begin
      mac_q <= cmd_mac;
      pid_q <= cmd_pid;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q     <= S_IDLE;
      act_q    <= A_BAD;
      kind_q   <= K_NONE;
      idx_q    <= '0;
      ptr_q    <= '0;
      fr_vld_q <= 1'b0;
      fr_idx_q <= '0;
      rd_q     <= '0;
      rdi_q    <= '0;
      rs_q     <= ST_IDLE;
      re_q     <= ERR_NONE;
    end else begin
      st_q     <= st_d;
      act_q    <= act_d;
      kind_q   <= kind_d;
      idx_q    <= idx_d;
      ptr_q    <= ptr_d;
      fr_vld_q <= fr_vld_d;
      fr_idx_q <= fr_idx_d;
      rd_q     <= rd_d;
      rdi_q    <= rdi_d;
      rs_q     <= rs_d;
      re_q     <= re_d;
    end
  end

  assign res_stat = rs_q;
  assign res_err  = re_q;
  assign rd_idx   = rdi_q;
  assign rd_mac   = rd_q.mac;
  assign rd_pid   = rd_q.pid;
  assign rd_vld   = rd_q.vld;
  assign rd_lck   = rd_q.lck;
  assign rd_flt   = rd_q.flt;
  assign rd_new   = rd_q.nw;
  assign rd_aged  = rd_q.agd;
endmodule

// File: rtl/mactbl_chk.sv
module mactbl_chk #(
  parameter int IRQ_W = 8,
  parameter int MW    = 48,
  parameter int PW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       res_stat,
  input logic [3:0]       res_err,
  input logic [MW-1:0]    rd_mac,
  input logic [PW-1:0]    rd_pid,
  input logic [IRQ_W-1:0] int_src,
  input logic [IRQ_W-1:0] int_mask,
  input logic             irq
);
  p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && res_stat != 2'b01) |=> (res_stat == 2'b01));

  p_done_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_stat == 2'b10 && !cmd_valid) |=> (res_stat == 2'b10));

  p_stat_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_stat != 2'b11);

  p_err_only_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_err != 4'h0) |-> (res_stat == 2'b10));

  p_rd_moves_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_mac) || !$stable(rd_pid)) |->
      ($past(res_stat) == 2'b01 && res_stat == 2'b10));

  p_end_sets_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_stat) == 2'b01 && res_stat == 2'b10) |-> int_src[5]);

  p_irq_needs_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(int_src & int_mask)));
endmodule

bind mac_cmd_engine mactbl_chk #(.IRQ_W(IRQ_W), .MW(mactbl_pkg::MAC_W), .PW(mactbl_pkg::PID_W)) i_chk (
  .clk(clk), .rst_n(rst_n_s), .cmd_valid(cmd_valid), .res_stat(res_stat),
  .res_err(res_err), .rd_mac(rd_mac), .rd_pid(rd_pid), .int_src(int_src),
  .int_mask(int_mask), .irq(irq)
);

// File: tb/test_mac_cmd_engine.sv
`timescale 1ns/1ps
module test_mac_cmd_engine;
  localparam logic [31:0] PFX = 32'h02AB_CD00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_op;
  logic [47:0] cmd_mac;
  logic [2:0]  cmd_pid;
  logic [7:0]  int_mask, int_clr;
  logic [1:0]  res_stat;
  logic [3:0]  res_err, rd_idx;
  logic [47:0] rd_mac;
  logic [2:0]  rd_pid;
  logic        rd_vld, rd_lck, rd_flt, rd_new, rd_aged;
  logic [7:0]  int_src;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mac_cmd_engine i_mac_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mac(cmd_mac), .cmd_pid(cmd_pid), .int_mask(int_mask), .int_clr(int_clr),
    .res_stat(res_stat), .res_err(res_err), .rd_idx(rd_idx), .rd_mac(rd_mac),
    .rd_pid(rd_pid), .rd_vld(rd_vld), .rd_lck(rd_lck), .rd_flt(rd_flt),
    .rd_new(rd_new), .rd_aged(rd_aged), .int_src(int_src), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] mlo;
    logic [2:0]  pid;
    logic [3:0]  err;
    logic        chk;
    logic [3:0]  idx;
    logic [15:0] emlo;
    logic [2:0]  epid;
    logic [4:0]  eflg;   // {valid, locked, filtered, new, aged}
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{8'h09, 16'h0001, 3'd1, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h09, 16'h0002, 3'd2, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h09, 16'h0003, 3'd1, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h09, 16'h0002, 3'd5, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h10, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd0, 16'h0001, 3'd1, 5'b10010},
    '{8'h11, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd1, 16'h0002, 3'd5, 5'b10010},
    '{8'h0C, 16'h0001, 3'd0, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h10, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h20, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd1, 16'h0002, 3'd5, 5'b10010},
    '{8'h21, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd2, 16'h0003, 3'd1, 5'b10010},
    '{8'h21, 16'h0000, 3'd0, 4'h1, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h0A, 16'h0003, 3'd0, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h50, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd2, 16'h0003, 3'd1, 5'b11010},
    '{8'h51, 16'h0000, 3'd0, 4'h1, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h0B, 16'h0002, 3'd0, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h60, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd1, 16'h0002, 3'd5, 5'b10110},
    '{8'h0D, 16'h0002, 3'd1, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h80, 16'h0000, 3'd1, 4'h0, 1'b1, 4'd1, 16'h0002, 3'd1, 5'b10110},
    '{8'h81, 16'h0000, 3'd1, 4'h0, 1'b1, 4'd2, 16'h0003, 3'd1, 5'b11010},
    '{8'h81, 16'h0000, 3'd1, 4'h1, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h30, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd1, 16'h0002, 3'd1, 5'b10110},
    '{8'h40, 16'h0000, 3'd0, 4'h1, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h0A, 16'h0009, 3'd0, 4'h1, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h0C, 16'h0009, 3'd0, 4'h1, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h09, 16'h0004, 3'd3, 4'h0, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h20, 16'h0000, 3'd0, 4'h0, 1'b1, 4'd0, 16'h0004, 3'd3, 5'b10010},
    '{8'h77, 16'h0000, 3'd0, 4'h3, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000},
    '{8'h12, 16'h0000, 3'd0, 4'h3, 1'b0, 4'd0, 16'h0000, 3'd0, 5'b00000}
  };

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h09:                      return "R4";
      8'h0A, 8'h0B, 8'h0D:        return "R5";
      8'h0C:                      return "R6";
      8'h10, 8'h11:               return "R7";
      8'h80, 8'h81:               return "R9";
      8'h20, 8'h21, 8'h30, 8'h40,
      8'h50, 8'h51, 8'h60:        return "R8";
      default:                    return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [47:0] mac,
                         input logic [2:0] pid, output int busy_n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_mac = mac; cmd_pid = pid;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_n = 0;
    while (res_stat == 2'b01 && busy_n < 200) begin
      busy_n++;
      @(negedge clk);
    end
  endtask

  task automatic expect_done(input string req, input logic [3:0] err);
    check(res_stat == 2'b10, req, "status", 64'(res_stat), 64'h2);
    check(res_err == err, req, "error", 64'(res_err), 64'(err));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int bn;
    logic [47:0] emac;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_mac = '0; cmd_pid = '0;
    int_mask = '0; int_clr = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(res_stat == 2'b00 && res_err == 4'h0, "R1", "stat in reset", {58'h0, res_stat, res_err}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_stat == 2'b00, "R1", "stat", 64'(res_stat), 64'h0);
    check(int_src == 8'h00 && irq == 1'b0, "R1", "irq state", {55'h0, irq, int_src}, 64'h0);
    check(rd_mac == 48'h0 && rd_idx == 4'h0, "R1", "readout", 64'(rd_mac), 64'h0);

    // R2 busy right after accept
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h10; cmd_mac = '0; cmd_pid = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(res_stat == 2'b01, "R2", "busy after accept", 64'(res_stat), 64'h1);
    while (res_stat == 2'b01) @(negedge clk);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i].op, {PFX, VEC[i].mlo}, VEC[i].pid, bn);
      expect_done(tag_of(VEC[i].op), VEC[i].err);
      if (VEC[i].chk) begin
        emac = (VEC[i].emlo == 16'h0) ? 48'h0 : {PFX, VEC[i].emlo};
        check(rd_idx == VEC[i].idx, tag_of(VEC[i].op), "rd_idx", 64'(rd_idx), 64'(VEC[i].idx));
        check(rd_mac == emac && rd_pid == VEC[i].epid, tag_of(VEC[i].op), "rd_mac/pid",
              {13'h0, rd_pid, rd_mac}, {13'h0, VEC[i].epid, emac});
        check({rd_vld, rd_lck, rd_flt, rd_new, rd_aged} == VEC[i].eflg, tag_of(VEC[i].op), "flags",
              64'({rd_vld, rd_lck, rd_flt, rd_new, rd_aged}), 64'(VEC[i].eflg));
      end
    end

    // R4 fill the 13 free slots, then overflow
    for (int i = 0; i < 13; i++) begin
      run_cmd(8'h09, {PFX, 16'h0100 + 16'(i)}, 3'd0, bn);
      expect_done("R4", 4'h0);
    end
    run_cmd(8'h09, {PFX, 16'h0200}, 3'd0, bn);
    expect_done("R4", 4'h2);
    run_cmd(8'h09, {PFX, 16'h0002}, 3'd6, bn);
    expect_done("R4", 4'h0);
    run_cmd(8'h80, 48'h0, 3'd6, bn);
    expect_done("R9", 4'h0);
    check(rd_idx == 4'd1 && rd_mac == {PFX, 16'h0002}, "R9", "port walk on full table", 64'(rd_idx), 64'h1);

    // R13 slot at index 2 is busy three cycles
    run_cmd(8'h0A, {PFX, 16'h0003}, 3'd0, bn);
    expect_done("R13", 4'h0);
    check(bn == 3, "R13", "busy cycles", 64'(bn), 64'd3);

    // R12 interrupt source, mask, clear
    check(int_src[5] == 1'b1 && irq == 1'b0, "R12", "src set, masked", {55'h0, irq, int_src}, 64'h20);
    int_mask = 8'h20;
    @(negedge clk);
    check(irq == 1'b1, "R12", "irq enabled", 64'(irq), 64'h1);
    int_clr = 8'h20;
    @(negedge clk);
    int_clr = 8'h00;
    check(int_src == 8'h00 && irq == 1'b0, "R12", "w1c clear", {55'h0, irq, int_src}, 64'h0);

    // R11 global reset opcode
    run_cmd(8'hFF, 48'h0, 3'd0, bn);
    expect_done("R11", 4'h0);
    check(int_src == 8'h20, "R11", "sources after clear", 64'(int_src), 64'h20);
    check(rd_mac == 48'h0 && rd_idx == 4'h0 && rd_vld == 1'b0, "R11", "readout cleared", 64'(rd_mac), 64'h0);
    run_cmd(8'h11, 48'h0, 3'd0, bn);
    expect_done("R10", 4'h0);
    check(rd_idx == 4'd0 && rd_vld == 1'b0, "R10", "next after clear starts at 0", 64'(rd_idx), 64'h0);
    run_cmd(8'h11, 48'h0, 3'd0, bn);
    check(rd_idx == 4'd1 && rd_mac == 48'h0, "R10", "next resumes", 64'(rd_idx), 64'h1);

    // R2 strobe while busy is ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h0A; cmd_mac = {PFX, 16'h0AAA}; cmd_pid = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h09; cmd_mac = {PFX, 16'h0BBB}; cmd_pid = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (res_stat == 2'b01) @(negedge clk);
    expect_done("R5", 4'h1);
    run_cmd(8'h20, 48'h0, 3'd0, bn);
    expect_done("R2", 4'h1);
    check(rd_idx == 4'd1, "R10", "readout kept on miss", 64'(rd_idx), 64'h1);
    run_cmd(8'h21, 48'h0, 3'd0, bn);
    expect_done("R10", 4'h1);

    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule